// File: doc/BRIEF.md
# Protected-Mode Far Jump Descriptor Checker

This block decides whether a far jump in protected mode may proceed. Each request carries the destination selector (table index, local-table bit and requested privilege level), the current privilege level, the limit of the descriptor table that the selector points into, and the fields of the descriptor already fetched for that selector. These fields are a kind code, the descriptor privilege level, the present bit, the conforming bit and the busy bit.

The block sorts the jump into one of four classes: a direct jump to a code segment, a jump through a call gate, a jump through a task gate, or a direct switch to a task state segment. It then runs the fault checks in a fixed order. One clock after the request strobe it presents either a one-hot action or a fault code, together with the selector that the fault reports. It does not read descriptor memory, save task state or check the limit of the final offset. For gate and task-state targets it also reports that the offset half of the far pointer is not used.

Top module: `fjmp_desc_check`

## Requirements
- R1: `valid_o` is high in the cycle after a cycle with `req_i` high and is low otherwise. While `valid_o` is low, `action_o`, `fault_o`, `fault_sel_o` and `keep_offset_o` are all zero.
- R2: A selector with index 0 and the local-table bit clear gives fault code 2'b01 (general protection, error code zero), whatever its RPL. `fault_sel_o` is then zero. Index 0 with the local-table bit set is not null.
- R3: An index greater than `tbl_limit_i` gives fault code 2'b10 (general protection with selector). An index equal to the limit passes this check.
- R4: Kind codes 0 (code segment), 1 (call gate), 2 (task gate) and 3 (task state segment) are legal. Kind codes 4 to 7 give fault code 2'b10.
- R5: For a code segment with the conforming bit clear, DPL not equal to CPL, or RPL greater than CPL, gives fault code 2'b10.
- R6: For a code segment with the conforming bit set, DPL greater than CPL gives fault code 2'b10. RPL plays no part.
- R7: For kinds 1, 2 and 3, DPL below CPL or below RPL gives fault code 2'b10.
- R8: For kind 3, a set local-table bit or a set busy bit gives fault code 2'b10. The busy bit has no effect for the other kinds.
- R9: A clear present bit gives fault code 2'b11 (not present with selector).
- R10: The checks run in this order: null, limit, kind, privilege, local/busy, present. Only the first one that fails is reported.
- R11: When no check fails, `fault_o` is 2'b00 and `action_o` has exactly the bit whose position equals the kind code set. Bit 0 is code, bit 1 is call gate, bit 2 is task gate and bit 3 is task state segment. On a fault, `action_o` is zero.
- R12: For fault codes 2'b10 and 2'b11, `fault_sel_o` equals {index, local-table bit, RPL}.
- R13: `keep_offset_o` is high only for an accepted code-segment jump. Gate and task-state targets report the pointer offset as unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, one cycle per check |
| sel_idx_i | input | IDX_W | Selector table index |
| sel_ti_i | input | 1 | Selector local-table bit |
| sel_rpl_i | input | 2 | Selector requested privilege level |
| cpl_i | input | 2 | Current privilege level |
| tbl_limit_i | input | IDX_W | Highest legal index in the selected table |
| d_kind_i | input | 3 | Descriptor kind code |
| d_dpl_i | input | 2 | Descriptor privilege level |
| d_present_i | input | 1 | Descriptor present bit |
| d_conf_i | input | 1 | Conforming bit (code segments) |
| d_busy_i | input | 1 | Busy bit (task state segments) |
| valid_o | output | 1 | Result valid |
| action_o | output | 4 | One-hot accepted action |
| fault_o | output | 2 | Fault code |
| fault_sel_o | output | IDX_W+3 | Selector reported with the fault |
| keep_offset_o | output | 1 | Pointer offset is used by the jump |

## Verification
The hardest case to reach is a request where several checks fail at once: each one must be hidden by an earlier one and exposed once the earlier one is repaired. Uniform random fields rarely line up this way. The stimulus therefore draws privilege levels, indices and limits from small ranges, so that privilege, limit, type and present failures overlap often. Directed cases then stack two failures, such as a bad kind code with a clear present bit or a privilege violation on a busy task state segment, and check which fault code wins.

// File: rtl/fjmp_pkg.sv
package fjmp_pkg;

  localparam int unsigned NUM_ACT   = 4;
  localparam int unsigned NUM_CHK   = 6;

  localparam logic [2:0] KIND_CODE  = 3'd0;
  localparam logic [2:0] KIND_CGATE = 3'd1;
  localparam logic [2:0] KIND_TGATE = 3'd2;
  localparam logic [2:0] KIND_TSS   = 3'd3;

  // check positions, lowest index has highest priority
  localparam int unsigned CHK_NULL  = 0;
  localparam int unsigned CHK_LIMIT = 1;
  localparam int unsigned CHK_KIND  = 2;
  localparam int unsigned CHK_PRIV  = 3;
  localparam int unsigned CHK_BUSY  = 4;
  localparam int unsigned CHK_PRES  = 5;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_GP0   = 2'b01,
    FLT_GPSEL = 2'b10,
    FLT_NPSEL = 2'b11
  } fault_e;

  function automatic logic kind_legal(input logic [2:0] kind);
    return kind <= KIND_TSS;
  endfunction

  // privilege violation for a legal kind
  function automatic logic priv_bad(input logic [2:0] kind, input logic conf,
                                    input logic [1:0] dpl, input logic [1:0] rpl,
                                    input logic [1:0] cpl);
    logic bad;
    if (kind == KIND_CODE) begin
      if (conf) bad = (dpl > cpl);
      else      bad = (dpl != cpl) || (rpl > cpl);
    end else begin
      bad = (dpl < cpl) || (dpl < rpl);
    end
    return bad;
  endfunction

endpackage

// File: rtl/fjmp_classify.sv
module fjmp_classify
  import fjmp_pkg::*;
#(
  parameter int unsigned IDX_W = 13
) (
  input  logic [IDX_W-1:0]   sel_idx,
  input  logic               sel_ti,
  input  logic [1:0]         sel_rpl,
  input  logic [1:0]         cpl,
  input  logic [IDX_W-1:0]   tbl_limit,
  input  logic [2:0]         kind,
  input  logic [1:0]         dpl,
  input  logic               present,
  input  logic               conf,
  input  logic               busy,
  output logic [NUM_CHK-1:0] fails,
  output logic [NUM_ACT-1:0] kind_hot
);

  always_comb begin
    fails            = '0;
    fails[CHK_NULL]  = (sel_idx == '0) && !sel_ti;
    fails[CHK_LIMIT] = (sel_idx > tbl_limit);
    fails[CHK_KIND]  = !kind_legal(kind);
    fails[CHK_PRIV]  = kind_legal(kind) && priv_bad(kind, conf, dpl, sel_rpl, cpl);
    fails[CHK_BUSY]  = (kind == KIND_TSS) && (sel_ti || busy);
    fails[CHK_PRES]  = !present;
  end

  for (genvar g = 0; g < NUM_ACT; g++) begin : g_kind
    assign kind_hot[g] = (kind == 3'(g));
  end

endmodule

// File: rtl/fjmp_prio.sv
module fjmp_prio
  import fjmp_pkg::*;
(
  input  logic [NUM_CHK-1:0] fails,
  output logic [NUM_CHK-1:0] first_hot,
  output fault_e             code
);

  // isolate lowest set bit: that check has the highest priority
  assign first_hot = fails & ~(fails - NUM_CHK'(1));

  always_comb begin
    if (first_hot == '0)             code = FLT_NONE;
    else if (first_hot[CHK_NULL])    code = FLT_GP0;
    else if (first_hot[CHK_PRES])    code = FLT_NPSEL;
    else                             code = FLT_GPSEL;
  end

endmodule

// File: rtl/fjmp_desc_check.sv
module fjmp_desc_check
  import fjmp_pkg::*;
#(
  parameter int unsigned IDX_W = 13,
  localparam int unsigned SEL_W = IDX_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [IDX_W-1:0]   sel_idx_i,
  input  logic               sel_ti_i,
  input  logic [1:0]         sel_rpl_i,
  input  logic [1:0]         cpl_i,
  input  logic [IDX_W-1:0]   tbl_limit_i,
  input  logic [2:0]         d_kind_i,
  input  logic [1:0]         d_dpl_i,
  input  logic               d_present_i,
  input  logic               d_conf_i,
  input  logic               d_busy_i,
  output logic               valid_o,
  output logic [NUM_ACT-1:0] action_o,
  output logic [1:0]         fault_o,
  output logic [SEL_W-1:0]   fault_sel_o,
  output logic               keep_offset_o
);

  logic [NUM_CHK-1:0] fails;
  logic [NUM_CHK-1:0] first_hot;
  logic [NUM_ACT-1:0] kind_hot;
  fault_e             code;
  logic               accept;
  logic               sel_faults;
  logic [SEL_W-1:0]   dest_sel;

  fjmp_classify #(.IDX_W(IDX_W)) u_cls (
    .sel_idx   (sel_idx_i),
    .sel_ti    (sel_ti_i),
    .sel_rpl   (sel_rpl_i),
    .cpl       (cpl_i),
    .tbl_limit (tbl_limit_i),
    .kind      (d_kind_i),
    .dpl       (d_dpl_i),
    .present   (d_present_i),
    .conf      (d_conf_i),
    .busy      (d_busy_i),
    .fails     (fails),
    .kind_hot  (kind_hot)
  );

  fjmp_prio u_prio (
    .fails     (fails),
    .first_hot (first_hot),
    .code      (code)
  );

  assign accept     = (code == FLT_NONE);
  assign sel_faults = (code == FLT_GPSEL) || (code == FLT_NPSEL);
  assign dest_sel   = {sel_idx_i, sel_ti_i, sel_rpl_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o       <= 1'b0;
      action_o      <= '0;
      fault_o       <= FLT_NONE;
      fault_sel_o   <= '0;
      keep_offset_o <= 1'b0;
    end else if (req_i) begin
      valid_o       <= 1'b1;
      action_o      <= accept ? kind_hot : '0;
      fault_o       <= code;
      fault_sel_o   <= sel_faults ? dest_sel : '0;
      keep_offset_o <= accept && kind_hot[KIND_CODE];
    end else begin
      valid_o       <= 1'b0;
      action_o      <= '0;
      fault_o       <= FLT_NONE;
      fault_sel_o   <= '0;
      keep_offset_o <= 1'b0;
    end
  end

endmodule

// File: rtl/fjmp_desc_check_chk.sv
module fjmp_desc_check_chk
  import fjmp_pkg::*;
#(
  parameter int unsigned IDX_W = 13,
  localparam int unsigned SEL_W = IDX_W + 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_i,
  input logic               valid_o,
  input logic [NUM_ACT-1:0] action_o,
  input logic [1:0]         fault_o,
  input logic [SEL_W-1:0]   fault_sel_o,
  input logic               keep_offset_o,
  input logic [NUM_CHK-1:0] fails,
  input logic [NUM_CHK-1:0] first_hot
);

  // R1
  valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(req_i));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (action_o == '0) && (fault_o == 2'b00) && (fault_sel_o == '0));

  // R11
  action_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(action_o));

  // R11
  fault_xor_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((fault_o == 2'b00) == ($countones(action_o) == 1)));

  // R2
  null_gp0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && fails[CHK_NULL] |=> (fault_o == 2'b01) && (fault_sel_o == '0));

  // R10
  limit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && fails[CHK_LIMIT] && !fails[CHK_NULL] |=> (fault_o == 2'b10));

  // R9
  present_np_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && first_hot[CHK_PRES] |=> (fault_o == 2'b11));

  // R13
  keep_offset_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keep_offset_o |-> action_o[0]);

endmodule

bind fjmp_desc_check fjmp_desc_check_chk #(.IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_i         (req_i),
  .valid_o       (valid_o),
  .action_o      (action_o),
  .fault_o       (fault_o),
  .fault_sel_o   (fault_sel_o),
  .keep_offset_o (keep_offset_o),
  .fails         (fails),
  .first_hot     (first_hot)
);

// File: tb/sim_fjmp_desc_check.sv
`timescale 1ns/1ps
module sim_fjmp_desc_check;

  localparam int IDX_W = 13;
  localparam int SEL_W = IDX_W + 3;
  localparam int RES_W = 1 + 4 + 2 + SEL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req = 1'b0;
  logic [IDX_W-1:0] idx = '0;
  logic             ti = 1'b0;
  logic [1:0]       rpl = '0;
  logic [1:0]       cpl = '0;
  logic [IDX_W-1:0] lim = '0;
  logic [2:0]       kind = '0;
  logic [1:0]       dpl = '0;
  logic             pres = 1'b0;
  logic             conf = 1'b0;
  logic             busy = 1'b0;
  logic             valid;
  logic [3:0]       action;
  logic [1:0]       fault;
  logic [SEL_W-1:0] fsel;
  logic             keep;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fjmp_desc_check #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .sel_idx_i(idx), .sel_ti_i(ti), .sel_rpl_i(rpl), .cpl_i(cpl),
    .tbl_limit_i(lim), .d_kind_i(kind), .d_dpl_i(dpl),
    .d_present_i(pres), .d_conf_i(conf), .d_busy_i(busy),
    .valid_o(valid), .action_o(action), .fault_o(fault),
    .fault_sel_o(fsel), .keep_offset_o(keep)
  );

  // expected {keep, action, fault, sel}, written as a sequential decision chain
  function automatic logic [RES_W-1:0] model();
    logic [1:0] f;
    logic [3:0] a;
    logic       k;
    logic [SEL_W-1:0] s;
    logic       pv;
    f = 2'd0; a = 4'd0; k = 1'b0;
    if (kind == 3'd0) pv = conf ? (dpl > cpl) : ((dpl != cpl) || (rpl > cpl));
    else              pv = (dpl < cpl) || (dpl < rpl);
    if (idx == 0 && !ti)                      f = 2'd1;
    else if (idx > lim)                       f = 2'd2;
    else if (kind >= 3'd4)                    f = 2'd2;
    else if (pv)                              f = 2'd2;
    else if (kind == 3'd3 && (ti || busy))    f = 2'd2;
    else if (!pres)                           f = 2'd3;
    else begin
      a = 4'b0001 << kind;
      k = (kind == 3'd0);
    end
    s = (f >= 2'd2) ? {idx, ti, rpl} : '0;
    return {k, a, f, s};
  endfunction

  task automatic check(input string tag, input logic [RES_W-1:0] got,
                       input logic [RES_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input string tag);
    logic [RES_W-1:0] exp;
    exp = model();
    req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    checks++;
    if (valid !== 1'b1) begin
      errors++;
      $display("FAIL R1 valid got=%b exp=1", valid);
    end
    check(tag, {keep, action, fault, fsel}, exp);
  endtask

  task automatic setf(input int i, input bit t, input int r, input int c,
                      input int l, input int kd, input int d, input bit p,
                      input bit cf, input bit b);
    idx = IDX_W'(i); ti = t; rpl = 2'(r); cpl = 2'(c); lim = IDX_W'(l);
    kind = 3'(kd); dpl = 2'(d); pres = p; conf = cf; busy = b;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 reset", {valid, keep, action, fault, fsel}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 null selector, any RPL
    setf(0, 0, 3, 0, 10, 0, 0, 1, 0, 0); apply("R2 null rpl3");
    // R2 index 0 in local table is not null
    setf(0, 1, 0, 0, 10, 0, 0, 1, 0, 0); apply("R2 ldt idx0 accepted");
    // R1 quiet cycle after a result
    @(negedge clk);
    check("R1 idle", {valid, keep, action, fault, fsel}, '0);
    // R3 limit boundary
    setf(7, 0, 0, 0, 7, 0, 0, 1, 0, 0); apply("R3 idx==limit");
    setf(8, 0, 0, 0, 7, 0, 0, 1, 0, 0); apply("R3 idx>limit");
    // R4 illegal kind
    setf(5, 0, 0, 0, 9, 6, 0, 1, 0, 0); apply("R4 kind6");
    // R11 each kind accepted, R13 offset use
    setf(5, 0, 0, 0, 9, 1, 0, 1, 0, 0); apply("R11 R13 call gate");
    setf(5, 0, 0, 0, 9, 2, 0, 1, 0, 0); apply("R11 R13 task gate");
    setf(5, 0, 0, 0, 9, 3, 0, 1, 0, 0); apply("R11 tss");
    // R5 nonconforming
    setf(4, 0, 3, 2, 9, 0, 2, 1, 0, 0); apply("R5 rpl>cpl");
    setf(4, 0, 1, 2, 9, 0, 1, 1, 0, 0); apply("R5 dpl!=cpl");
    // R6 conforming
    setf(4, 0, 3, 2, 9, 0, 1, 1, 1, 0); apply("R6 dpl<cpl ok");
    setf(4, 0, 0, 1, 9, 0, 2, 1, 1, 0); apply("R6 dpl>cpl");
    // R7 gate privilege
    setf(4, 0, 3, 1, 9, 1, 2, 1, 0, 0); apply("R7 dpl<rpl");
    setf(4, 0, 0, 3, 9, 2, 2, 1, 0, 0); apply("R7 dpl<cpl");
    // R8 tss busy and local bit, busy ignored on code
    setf(4, 0, 0, 0, 9, 3, 0, 1, 0, 1); apply("R8 tss busy");
    setf(4, 1, 0, 0, 9, 3, 0, 1, 0, 0); apply("R8 tss local");
    setf(4, 0, 0, 0, 9, 0, 0, 1, 0, 1); apply("R8 busy on code ignored");
    // R9 R12 not present
    setf(6, 1, 2, 2, 9, 1, 3, 0, 0, 0); apply("R9 R12 not present");
    // R10 stacked failures
    setf(4, 0, 0, 0, 9, 7, 0, 0, 0, 0); apply("R10 kind before present");
    setf(4, 0, 0, 3, 9, 3, 0, 0, 0, 1); apply("R10 priv before busy");
    setf(0, 0, 0, 0, 0, 5, 0, 0, 0, 0); apply("R10 null first");
    setf(12, 0, 0, 3, 3, 0, 0, 1, 0, 0); apply("R10 limit before priv");

    // random mix with narrow ranges to stack failures
    for (int n = 0; n < 400; n++) begin
      setf($urandom % 12, ($urandom % 4) == 0, $urandom % 4, $urandom % 4,
           $urandom % 14, (($urandom % 8) < 6) ? $urandom % 4 : 4 + $urandom % 4,
           $urandom % 4, ($urandom % 5) != 0, $urandom % 2, $urandom % 2);
      apply("R10 R12 random");
      if ($urandom % 3 == 0) @(negedge clk);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule